// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block derives the 16x oversampling tick for a UART receiver and transmitter from a fast reference clock. The reference clock is qualified by a clock-enable input. Each enabled cycle first passes through a pre-divider whose ratio comes from a small fixed table indexed by a 3-bit code. The pre-divided enables then drive a phase accumulator that realises a programmable numerator/denominator ratio, so no hardware divider is needed. A tick is a single-cycle pulse. A second output, the bit strobe, rises together with every sixteenth tick and marks one serial bit period.

Software programs the block through a small write port with three register slots: the pre-divider code, the numerator and the denominator. The numerator and the denominator are stored as their true value minus one. A new ratio takes effect only when a numerator write is followed by a denominator write with no other write in between. That update clears all running phase state, so the first period after a change is a whole period. With a numerator of 16 the oversampling factor cancels, and the bit period is simply the denominator times the pre-divide count, in reference cycles.

The design is built around a two-state pair-loading state machine. In `PAIR_IDLE` no numerator is waiting. A numerator write takes it to `PAIR_ARMED`. In `PAIR_ARMED` a numerator is waiting: a denominator write loads the active pair and returns to `PAIR_IDLE`, any other write returns to `PAIR_IDLE` without loading, and a further numerator write stays in `PAIR_ARMED`. Cycles with no write keep the current state.

Top module: `frac_baud_gen`

## Requirements
- R1: `wr_sel` 0 writes the pre-divider code from `wr_data[2:0]`. Codes 0 to 7 select divide counts 6, 5, 4, 3, 2, 1, 7 and 1 respectively. The pre-divider emits one enable for every that many cycles with `ref_en` high. A code write or a pair load restarts its count.
- R2: `wr_sel` 1 writes the numerator and `wr_sel` 2 writes the denominator, from `wr_data[15:0]`. Each register holds its true value minus one. `wr_sel` 3 writes nothing.
- R3: After a pair load, the number of ticks produced by the first k pre-divided enables is floor(k·N/D), where N and D are the true numerator and denominator.
- R4: `bit_strobe` is high only in a cycle where `tick16` is high. It is high on every sixteenth tick counted from reset or from the last pair load.
- R5: The active ratio changes only on a denominator write whose previous write was a numerator write. Idle cycles between the two writes do not break the pair.
- R6: A denominator write that is not directly preceded by a numerator write, and a numerator write followed by any other write, leave the tick rate unchanged.
- R7: A pair load clears the accumulator, the sixteen-tick phase and the pre-divider count. No tick or strobe appears in the cycle after the load.
- R8: When the true numerator exceeds the true denominator, the block produces exactly one tick per pre-divided enable.
- R9: While `rst_n` is low both outputs are low. After reset the block uses divide-by-1 with numerator 16 and denominator 16, giving one tick for every cycle with `ref_en` high.
- R10: `tick16` is registered. It goes high only in the cycle after an enabled cycle in which `ref_en` was high, and it produces no ticks while `ref_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | Clock enable qualifying reference cycles |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register slot: 0 pre-divider code, 1 numerator, 2 denominator, 3 none |
| wr_data | input | 16 | Write data |
| tick16 | output | 1 | Single-cycle 16x oversampling tick |
| bit_strobe | output | 1 | Single-cycle strobe on every sixteenth tick |

## Verification
A wrong accumulator value or active pair shows at the ports as a wrong count of ticks over a fixed window. The error therefore appears within one denominator's worth of pre-divided enables. A sixteen-tick phase counter that is off by any amount moves the first strobe after a load away from the sixteenth tick, so it is seen within sixteen ticks. A pair-loading state machine that loads out of order, or that fails to load, changes the tick count over the very next window. The bench compares tick and strobe totals against floor-based expectations over windows long enough to expose each of these faults.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

    // Register slot selected by the write port.
    typedef enum logic [1:0] {
        SLOT_PRESEL = 2'd0,
        SLOT_NUM    = 2'd1,
        SLOT_DEN    = 2'd2,
        SLOT_NONE   = 2'd3
    } slot_e;

    // Pair-loading state machine.
    typedef enum logic {
        PAIR_IDLE  = 1'b0,
        PAIR_ARMED = 1'b1
    } pair_state_e;

    localparam logic [2:0] PRESEL_RESET = 3'd5;   // divide by 1

    // Fixed pre-divider table: the code order is part of the behaviour.
    function automatic logic [2:0] prediv_count(input logic [2:0] code);
        logic [2:0] r;
        unique case (code)
            3'd0:    r = 3'd6;
            3'd1:    r = 3'd5;
            3'd2:    r = 3'd4;
            3'd3:    r = 3'd3;
            3'd4:    r = 3'd2;
            3'd5:    r = 3'd1;
            3'd6:    r = 3'd7;
            default: r = 3'd1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/frac_baud_prediv.sv
module frac_baud_prediv
    import frac_baud_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              pd_en
);

    logic [2:0] count_q;
    logic [2:0] ratio;
    logic       at_last;

    always_comb begin
        ratio   = prediv_count(code[2:0]);
        at_last = (count_q == (ratio - 3'd1));
        pd_en   = ref_en && at_last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count_q <= '0;
        end else if (ref_en) begin
            count_q <= at_last ? 3'd0 : count_q + 3'd1;
        end
    end

endmodule

// File: rtl/frac_baud_pair_fsm.sv
module frac_baud_pair_fsm
    import frac_baud_pkg::*;
#(
    parameter int RATIO_W = 16,
    parameter int CODE_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [RATIO_W-1:0] wr_data,
    output logic [CODE_W-1:0]  presel,
    output logic               presel_wr,
    output logic [RATIO_W-1:0] act_num,
    output logic [RATIO_W-1:0] act_den,
    output logic               pair_load
);

    localparam logic [RATIO_W-1:0] NUM_RESET = RATIO_W'(15);
    localparam logic [RATIO_W-1:0] DEN_RESET = RATIO_W'(15);

    pair_state_e state_q, state_d;
    slot_e       slot;
    logic        wr_num, wr_den;
    logic [RATIO_W-1:0] pend_num_q, pend_den_q;

    always_comb begin
        slot      = slot_e'(wr_sel);
        wr_num    = wr_en && (slot == SLOT_NUM);
        wr_den    = wr_en && (slot == SLOT_DEN);
        presel_wr = wr_en && (slot == SLOT_PRESEL);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PAIR_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PAIR_IDLE: begin
                if (wr_num) state_d = PAIR_ARMED;
            end
            PAIR_ARMED: begin
                if (wr_en) state_d = wr_num ? PAIR_ARMED : PAIR_IDLE;
            end
        endcase
    end

    // Outputs of the machine
    always_comb begin
        pair_load = 1'b0;
        unique case (state_q)
            PAIR_IDLE:  pair_load = 1'b0;
            PAIR_ARMED: pair_load = wr_den;
        endcase
    end

    // Register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presel     <= CODE_W'(PRESEL_RESET);
            pend_num_q <= NUM_RESET;
            pend_den_q <= DEN_RESET;
            act_num    <= NUM_RESET;
            act_den    <= DEN_RESET;
        end else begin
            if (presel_wr) presel     <= wr_data[CODE_W-1:0];
            if (wr_num)    pend_num_q <= wr_data;
            if (wr_den)    pend_den_q <= wr_data;
            if (pair_load) begin
                act_num <= pend_num_q;
                act_den <= wr_data;
            end
        end
    end

endmodule

// File: rtl/frac_baud_accum.sv
module frac_baud_accum #(
    parameter int RATIO_W = 16,
    parameter int OVS     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               pd_en,
    input  logic [RATIO_W-1:0] num_reg,
    input  logic [RATIO_W-1:0] den_reg,
    output logic               tick,
    output logic               strobe
);

    localparam int AW   = RATIO_W + 1;
    localparam int PH_W = $clog2(OVS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

    logic [AW-1:0]   acc_q;
    logic [PH_W-1:0] phase_q;
    logic [AW-1:0]   num_t, den_t, num_eff;
    logic [AW:0]     sum, rem;
    logic            hit;

    always_comb begin
        num_t   = {1'b0, num_reg} + AW'(1);
        den_t   = {1'b0, den_reg} + AW'(1);
        num_eff = (num_t > den_t) ? den_t : num_t;
        sum     = {1'b0, acc_q} + {1'b0, num_eff};
        rem     = sum - {1'b0, den_t};
        hit     = (sum >= {1'b0, den_t});
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q   <= '0;
            phase_q <= '0;
            tick    <= 1'b0;
            strobe  <= 1'b0;
        end else begin
            tick   <= pd_en && hit;
            strobe <= pd_en && hit && (phase_q == PH_LAST);
            if (pd_en) begin
                acc_q <= hit ? rem[AW-1:0] : sum[AW-1:0];
                if (hit) phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
            end
        end
    end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
    parameter int RATIO_W = 16,
    parameter int CODE_W  = 3,
    parameter int OVS     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_en,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [RATIO_W-1:0] wr_data,
    output logic               tick16,
    output logic               bit_strobe
);

    logic [CODE_W-1:0]  presel_r;
    logic               presel_wr;
    logic [RATIO_W-1:0] act_num_r, act_den_r;
    logic               pair_load;
    logic               pd_restart;
    logic               pd_en;

    assign pd_restart = pair_load || presel_wr;

    frac_baud_pair_fsm #(.RATIO_W(RATIO_W), .CODE_W(CODE_W)) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .presel    (presel_r),
        .presel_wr (presel_wr),
        .act_num   (act_num_r),
        .act_den   (act_den_r),
        .pair_load (pair_load)
    );

    frac_baud_prediv #(.CODE_W(CODE_W)) u_prediv (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_en  (ref_en),
        .restart (pd_restart),
        .code    (presel_r),
        .pd_en   (pd_en)
    );

    frac_baud_accum #(.RATIO_W(RATIO_W), .OVS(OVS)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (pair_load),
        .pd_en   (pd_en),
        .num_reg (act_num_r),
        .den_reg (act_den_r),
        .tick    (tick16),
        .strobe  (bit_strobe)
    );

endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
    parameter int RATIO_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ref_en,
    input logic               pair_load,
    input logic               tick16,
    input logic               bit_strobe,
    input logic [RATIO_W-1:0] act_num,
    input logic [RATIO_W-1:0] act_den
);

    logic [3:0] ticks_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n || pair_load) ticks_seen_q <= '0;
        else if (tick16)         ticks_seen_q <= ticks_seen_q + 4'd1;
    end

    AST_STROBE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> tick16);                                           // R4
    AST_STROBE_ON_SIXTEENTH: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> (ticks_seen_q == 4'd15));                          // R4
    AST_NO_EARLY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick16 && ticks_seen_q == 4'd15) |-> bit_strobe);                // R4
    AST_TICK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick16 |-> $past(ref_en));                                        // R10
    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pair_load |=> (!tick16 && !bit_strobe));                          // R7
    AST_PAIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_load |=> ($stable(act_num) && $stable(act_den)));           // R5

endmodule

bind frac_baud_gen frac_baud_gen_chk #(.RATIO_W(RATIO_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_en     (ref_en),
    .pair_load  (pair_load),
    .tick16     (tick16),
    .bit_strobe (bit_strobe),
    .act_num    (act_num_r),
    .act_den    (act_den_r)
);

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [15:0] wr_data = 16'd0;
    logic        tick16, bit_strobe;

    int n_checks = 0;
    int n_errs   = 0;

    always #2 clk = ~clk;   // 250 MHz

    frac_baud_gen u_frac_baud_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_en     (ref_en),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .tick16     (tick16),
        .bit_strobe (bit_strobe)
    );

    // {code, num reg, den reg, window, expected ticks, expected strobes}
    localparam int NV = 10;
    localparam int VEC [NV][6] = '{
        '{5, 15, 15, 480, 480, 30},   // R1 divide 1, R2 16/16
        '{5,  0,  2, 480, 160, 10},   // 1/3
        '{0, 15, 15, 480,  80,  5},   // R1 divide 6
        '{6,  2,  4, 480,  40,  2},   // divide 7, 3/5
        '{3, 15, 39, 480,  64,  4},   // divide 3, 16/40
        '{5, 99,  9, 480, 480, 30},   // R8 clamp 100/10
        '{7,  6,  8, 480, 373, 23},   // code 7 divides by 1, 7/9
        '{4,  4,  5, 480, 200, 12},   // divide 2, 5/6
        '{2,  0,  0, 480, 120,  7},   // divide 4, 1/1
        '{1,  1,  6, 480,  27,  1}    // divide 5, 2/7
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int val);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = 2'(sel);
        wr_data = 16'(val);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_sel  = 2'd3;
    endtask

    task automatic count(input int n, output int t, output int s);
        t = 0;
        s = 0;
        repeat (n) begin
            @(negedge clk);
            if (tick16)     t++;
            if (bit_strobe) s++;
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int t, s, first;

        // R9: outputs low in reset, then one tick per enabled cycle
        repeat (4) @(negedge clk);
        check("R9 tick in reset", int'(tick16), 0);
        check("R9 strobe in reset", int'(bit_strobe), 0);
        rst_n = 1'b1;
        count(32, t, s);
        check("R9 reset-default ticks", t, 32);
        check("R9 R4 reset-default strobes", s, 2);

        // Table of ratios
        for (int v = 0; v < NV; v++) begin
            wr(0, VEC[v][0]);
            wr(1, VEC[v][1]);
            wr(2, VEC[v][2]);
            count(VEC[v][3], t, s);
            check($sformatf("%s vec%0d ticks", (v == 5) ? "R8" : "R1 R2 R3 R7", v), t, VEC[v][4]);
            check($sformatf("R4 vec%0d strobes", v), s, VEC[v][5]);
        end

        // R10: no ticks while ref_en low
        @(negedge clk);
        ref_en = 1'b0;
        count(50, t, s);
        check("R10 ticks with ref_en low", t, 0);
        ref_en = 1'b1;

        // R6: lone denominator write and interrupted pair
        wr(0, 5);
        wr(1, 0);
        wr(2, 1);                     // 1/2
        count(100, t, s);
        check("R5 base 1/2 ticks", t, 50);
        wr(2, 0);                     // lone den: would be 1/1
        count(100, t, s);
        check("R6 lone denominator", t, 50);
        wr(1, 0);
        wr(0, 5);                     // breaks the pair
        wr(2, 0);
        count(100, t, s);
        check("R6 interrupted pair", t, 50);
        wr(1, 0);
        wr(3, 0);                     // empty slot also breaks the pair
        wr(2, 0);
        count(100, t, s);
        check("R6 empty-slot write breaks pair", t, 50);

        // R5: idle cycles between numerator and denominator keep the pair
        wr(1, 0);
        repeat (5) @(negedge clk);
        wr(2, 3);                     // 1/4
        count(100, t, s);
        check("R5 pair across idle gap", t, 25);

        // R7: load clears the phase; first strobe on the sixteenth tick
        wr(1, 15);
        wr(2, 15);
        count(8, t, s);
        check("R7 partial run ticks", t, 8);
        wr(1, 15);
        wr(2, 15);
        check("R7 no tick after load", int'(tick16), 0);
        first = 0;
        for (int i = 1; i <= 16; i++) begin
            @(negedge clk);
            if (bit_strobe && first == 0) first = i;
        end
        check("R7 R4 first strobe index after load", first, 16);

        summary();
        $finish;
    end

endmodule